// File: doc/BRIEF.md
# Dual-Rail to Level-Encoded Output Converter

This block sits at the output of a function block that computes in four-phase dual-rail form and hands its result on as a level-encoded two-phase (LEDR) word. Each result bit arrives as a true/false rail pair. A pair with one rail high carries a value. A pair with both rails low is the return-to-zero spacer. For every bit the converter produces a data wire and a parity wire. The data wire carries the bit value. The parity wire is set so that data XOR parity equals the phase of the token in flight. A new token therefore moves exactly one of the two wires of each bit.

Bits are re-encoded one at a time, each as soon as its own rail pair evaluates. During the spacer the LEDR wires hold their values. A token-phase register follows the incoming token phase only while the function block is quiescent. It closes as soon as word-level four-phase completion is flagged, and it stays closed until the reset wave has cleared every bit. The block also reports two completion flags. The first is four-phase word completion. The second is LEDR output completion, formed from per-bit XOR of the output rails. Both flags behave like C-element trees: they change only when all bits agree. The model is synchronous, and every output is registered.

Top module: `ledr_out_conv`

## Requirements
- R1: One clock edge after a bit has only its true rail high, its `ledr_data` bit is 1. One edge after it has only its false rail high, that bit is 0.
- R2: While a bit's rails are both low (spacer), its `ledr_data` and `ledr_par` bits keep their values.
- R3: When a bit is re-encoded, its `ledr_par` bit is written so that `ledr_data ^ ledr_par` equals the `tok_phase` value in effect at that edge.
- R4: Each bit is re-encoded independently. An evaluated bit shows its new value while other bits are still in the spacer, and `fp_done` is still 0 at that point.
- R5: `tok_phase` takes the value of `in_phase` one edge later while `fp_done` is 0. While `fp_done` is 1 it holds, whatever `in_phase` does.
- R6: `fp_done` becomes 1 one edge after every bit has a rail high. It becomes 0 one edge after every rail is low. Otherwise it holds, including during a partial reset.
- R7: `ledr_done` becomes 1 one edge after every bit has `ledr_data ^ ledr_par` = 1. It becomes 0 one edge after every bit has that XOR = 0. Otherwise it holds.
- R8: A bit whose true and false rails are both high is an illegal code. Its LEDR outputs are left unchanged.
- R9: After synchronous active-low reset, `ledr_data`, `ledr_par`, `tok_phase`, `fp_done` and `ledr_done` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fp_true | input | N | True rails of the dual-rail result |
| fp_false | input | N | False rails of the dual-rail result |
| in_phase | input | 1 | Phase of the token being processed |
| ledr_data | output | N | LEDR data wires |
| ledr_par | output | N | LEDR parity wires |
| tok_phase | output | 1 | Latched token phase |
| fp_done | output | 1 | Four-phase word completion |
| ledr_done | output | 1 | LEDR output completion (phase of last complete word) |

## Verification
The assertions assume that `in_phase` changes only while `fp_done` is 0 and the rails are in the spacer. They also assume that a bit's rails go high only after `tok_phase` already holds the new phase, and that the function block never leaves a rail high past its own reset. The stimulus follows this pattern. It sets the new phase, waits one cycle, and then raises rails either all at once or one bit per cycle. It clears the rails in two halves. The only deliberate departures are two probes. One flips `in_phase` while the latch is closed. The other drives a both-rails-high pair during the spacer, where the rules require no output change.

// File: rtl/ledr_conv_pkg.sv
// Package: shared types and helpers for the dual-rail to LEDR output converter.
// Assumes nothing beyond the default widths set by the top module.
package ledr_conv_pkg;

    // Word-level completion state as seen by a C-element style tree.
    typedef enum logic [1:0] {
        CT_NONE  = 2'b00,   // every input low
        CT_MIXED = 2'b01,   // inputs disagree
        CT_ALL   = 2'b10    // every input high
    } ctree_state_e;

    // One LEDR-encoded bit.
    typedef struct packed {
        logic data;
        logic par;
    } ledr_bit_t;

    // Re-encode an evaluated value into an LEDR pair for the given phase.
    function automatic ledr_bit_t ledr_encode(input logic value, input logic phase);
        ledr_bit_t r;
        r.data = value;
        r.par  = value ^ phase;
        return r;
    endfunction

endpackage

// File: rtl/tok_phase_latch.sv
// Module: token-phase register. It follows the incoming token phase while the
// function block is idle, and it is closed while word completion is flagged.
// Assumes: phase_in is stable from the cycle before the first rail rises.
module tok_phase_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic phase_in,
    input  logic closed,
    output logic phase_o
);

    // Capture the new phase only while the four-phase side is quiescent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_o <= 1'b0;
        end else if (!closed) begin
            phase_o <= phase_in;
        end
    end

    // R5: the phase cannot move while completion is flagged.
    a_r5_closed_hold: assert property (@(posedge clk) disable iff (!rst_n)
        closed |=> $stable(phase_o));

    // R5: while open, the register follows its input one edge later.
    a_r5_open_follow: assert property (@(posedge clk) disable iff (!rst_n)
        !closed |=> (phase_o == $past(phase_in)));

endmodule

// File: rtl/ledr_bit_enc.sv
// Module: one-bit four-phase dual-rail to LEDR encoder. It sets or clears the
// data wire when a rail rises, holds through the spacer, and writes parity
// from the value and the latched token phase.
// Assumes: tok_phase settled at least one edge before either rail rises.
module ledr_bit_enc
    import ledr_conv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rail_t,
    input  logic rail_f,
    input  logic tok_phase,
    output logic data_o,
    output logic par_o
);

    ledr_bit_t cur_q;
    logic      eval_ok;

    // A legal evaluated code has exactly one rail high.
    always_comb begin
        eval_ok = rail_t ^ rail_f;
    end

    // Re-encode on a legal code; hold during the spacer or an illegal code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else if (eval_ok) begin
            cur_q <= ledr_encode(rail_t, tok_phase);
        end
    end

    assign data_o = cur_q.data;
    assign par_o  = cur_q.par;

    // R1: the true rail drives a 1 and the false rail drives a 0.
    a_r1_true_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (rail_t && !rail_f) |=> data_o);
    a_r1_false_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rail_f && !rail_t) |=> !data_o);

    // R3: the phase of the new pair matches the token phase.
    a_r3_phase_match: assert property (@(posedge clk) disable iff (!rst_n)
        (rail_t ^ rail_f) |=> ((data_o ^ par_o) == $past(tok_phase)));

    // R2: the spacer leaves both wires untouched.
    a_r2_spacer_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!rail_t && !rail_f) |=> ($stable(data_o) && $stable(par_o)));

    // R8: an illegal code leaves both wires untouched.
    a_r8_illegal_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rail_t && rail_f) |=> ($stable(data_o) && $stable(par_o)));

endmodule

// File: rtl/cel_tree.sv
// Module: registered C-element reduction over W inputs. The output rises when
// every input is high, falls when every input is low, and holds otherwise.
// Assumes: W >= 1.
module cel_tree
    import ledr_conv_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] vec,
    output logic         done
);

    ctree_state_e st;

    // Classify the input vector as all-high, all-low or mixed.
    always_comb begin
        if (&vec)       st = CT_ALL;
        else if (~|vec) st = CT_NONE;
        else            st = CT_MIXED;
    end

    // Update the output only when the inputs agree.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else begin
            case (st)
                CT_ALL:  done <= 1'b1;
                CT_NONE: done <= 1'b0;
                default: done <= done;
            endcase
        end
    end

    // R6/R7: rising on full agreement, falling on full clear, else holding.
    a_r6_all_high: assert property (@(posedge clk) disable iff (!rst_n)
        (&vec) |=> done);
    a_r6_all_low: assert property (@(posedge clk) disable iff (!rst_n)
        (~|vec) |=> !done);
    a_r7_mixed_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&vec) && (|vec)) |=> $stable(done));

endmodule

// File: rtl/ledr_out_conv.sv
// Module: top of the dual-rail to LEDR output converter. It holds one encoder
// per bit, a four-phase completion tree, an LEDR completion tree fed by
// per-bit XOR of the outputs, and the token-phase register.
// Assumes: the function block returns to the spacer after each token, and
// in_phase changes only while the word is in the spacer.
module ledr_out_conv #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] fp_true,
    input  logic [N-1:0] fp_false,
    input  logic         in_phase,
    output logic [N-1:0] ledr_data,
    output logic [N-1:0] ledr_par,
    output logic         tok_phase,
    output logic         fp_done,
    output logic         ledr_done
);

    localparam int LAST = N - 1;

    logic [N-1:0] bit_fp_cd;
    logic [N-1:0] bit_ledr_cd;

    // Phase register, closed while word completion is flagged.
    tok_phase_latch u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase_in (in_phase),
        .closed   (fp_done),
        .phase_o  (tok_phase)
    );

    // One encoder and two per-bit detectors for each bit.
    for (genvar i = 0; i <= LAST; i++) begin : g_bit
        ledr_bit_enc u_enc (
            .clk       (clk),
            .rst_n     (rst_n),
            .rail_t    (fp_true[i]),
            .rail_f    (fp_false[i]),
            .tok_phase (tok_phase),
            .data_o    (ledr_data[i]),
            .par_o     (ledr_par[i])
        );

        // Per-bit completion for both encodings.
        always_comb begin
            bit_fp_cd[i]   = fp_true[i] | fp_false[i];
            bit_ledr_cd[i] = ledr_data[i] ^ ledr_par[i];
        end
    end

    // Word-level four-phase completion.
    cel_tree #(.W(N)) u_fp_cd (
        .clk   (clk),
        .rst_n (rst_n),
        .vec   (bit_fp_cd),
        .done  (fp_done)
    );

    // Word-level LEDR output completion.
    cel_tree #(.W(N)) u_ledr_cd (
        .clk   (clk),
        .rst_n (rst_n),
        .vec   (bit_ledr_cd),
        .done  (ledr_done)
    );

    // R4: a bit's outputs can move while the word is not yet complete.
    a_r4_no_word_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (!fp_done && ((fp_true[0] ^ fp_false[0]) && !(&bit_fp_cd)))
            |=> (ledr_data[0] == $past(fp_true[0])));

endmodule

// File: tb/ledr_out_conv_test.sv
`timescale 1ns/1ps
module ledr_out_conv_test;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] fp_true = '0;
    logic [N-1:0] fp_false = '0;
    logic         in_phase = 1'b0;
    logic [N-1:0] ledr_data;
    logic [N-1:0] ledr_par;
    logic         tok_phase;
    logic         fp_done;
    logic         ledr_done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic ph = 1'b0;
    logic fp_prev = 1'b0;
    logic [2*N-1:0] exp_q[$];

    always #2.5 clk = ~clk;

    ledr_out_conv #(.N(N)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .fp_true   (fp_true),
        .fp_false  (fp_false),
        .in_phase  (in_phase),
        .ledr_data (ledr_data),
        .ledr_par  (ledr_par),
        .tok_phase (tok_phase),
        .fp_done   (fp_done),
        .ledr_done (ledr_done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pop one expected word on each rise of fp_done (R1, R3).
    always @(negedge clk) begin
        if (rst_n && fp_done && !fp_prev) begin
            if (exp_q.size() == 0) begin
                chk("R1 unexpected word", 32'd1, 32'd0);
            end else begin
                logic [2*N-1:0] e;
                e = exp_q.pop_front();
                chk("R1 data", {24'd0, ledr_data}, {24'd0, e[2*N-1:N]});
                chk("R3 parity", {24'd0, ledr_par}, {24'd0, e[N-1:0]});
            end
        end
        fp_prev = fp_done;
    end

    // Driver: send one token, either all bits together or one bit per cycle.
    task automatic send_tok(input logic [N-1:0] v, input bit serial);
        logic [N-1:0] hold_d;
        logic [N-1:0] hold_p;
        logic         old_done;
        ph = ~ph;
        in_phase = ph;
        @(negedge clk);
        chk("R5 open follow", {31'd0, tok_phase}, {31'd0, ph});
        exp_q.push_back({v, v ^ {N{ph}}});
        old_done = ledr_done;
        if (serial) begin
            for (int i = 0; i < N; i++) begin
                fp_true[i]  = v[i];
                fp_false[i] = ~v[i];
                @(negedge clk);
                if (i < N - 1) begin
                    chk("R4 early bit", {31'd0, ledr_data[i]}, {31'd0, v[i]});
                    chk("R4 no word yet", {31'd0, fp_done}, 32'd0);
                    chk("R7 hold partial", {31'd0, ledr_done}, {31'd0, old_done});
                end
            end
        end else begin
            fp_true  = v;
            fp_false = ~v;
            @(negedge clk);
        end
        chk("R6 word done", {31'd0, fp_done}, 32'd1);
        @(negedge clk);
        chk("R7 ledr done", {31'd0, ledr_done}, {31'd0, ph});
        // Probe the closed latch with a premature phase change.
        in_phase = ~ph;
        @(negedge clk);
        chk("R5 closed hold", {31'd0, tok_phase}, {31'd0, ph});
        hold_d = ledr_data;
        hold_p = ledr_par;
        // Partial reset: lower half first.
        fp_true[N/2-1:0]  = '0;
        fp_false[N/2-1:0] = '0;
        @(negedge clk);
        chk("R6 partial hold", {31'd0, fp_done}, 32'd1);
        chk("R2 spacer data", {24'd0, ledr_data}, {24'd0, hold_d});
        fp_true  = '0;
        fp_false = '0;
        @(negedge clk);
        chk("R6 word clear", {31'd0, fp_done}, 32'd0);
        chk("R5 still closed", {31'd0, tok_phase}, {31'd0, ph});
        chk("R2 spacer parity", {24'd0, ledr_par}, {24'd0, hold_p});
        @(negedge clk);
        chk("R5 reopened", {31'd0, tok_phase}, {31'd0, ~ph});
        in_phase = ph;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 data", {24'd0, ledr_data}, 32'd0);
        chk("R9 parity", {24'd0, ledr_par}, 32'd0);
        chk("R9 phase", {31'd0, tok_phase}, 32'd0);
        chk("R9 fp_done", {31'd0, fp_done}, 32'd0);
        chk("R9 ledr_done", {31'd0, ledr_done}, 32'd0);

        send_tok(8'hA5, 1'b0);
        send_tok(8'h3C, 1'b1);
        send_tok(8'h00, 1'b0);
        send_tok(8'hFF, 1'b1);
        send_tok(8'h81, 1'b0);

        // R8: both rails high on one bit during the spacer.
        begin
            logic [N-1:0] d0;
            logic [N-1:0] p0;
            d0 = ledr_data;
            p0 = ledr_par;
            fp_true[2]  = 1'b1;
            fp_false[2] = 1'b1;
            @(negedge clk);
            chk("R8 illegal data", {24'd0, ledr_data}, {24'd0, d0});
            chk("R8 illegal parity", {24'd0, ledr_par}, {24'd0, p0});
            chk("R8 no word", {31'd0, fp_done}, 32'd0);
            fp_true  = '0;
            fp_false = '0;
            @(negedge clk);
        end

        send_tok(8'h5A, 1'b1);
        chk("R1 queue drained", exp_q.size(), 32'd0);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule